// File: doc/BRIEF.md
# Secured Configuration Store Controller

This block sits in front of the configuration storage of a programmable logic device. It holds three things: a word-organised fuse pattern, a user signature of eight bytes, and one security bit. A host drives a single command port. Each command carries an operation code, an address and a data word. The controller answers with a done pulse and, when it refuses a command, a denied flag.

The operations are:
- write a fuse word and read a fuse word back for verification;
- write and read signature bytes;
- set the security bit;
- send a preload value to the device's output registers;
- perform a full erase.

Once the security bit is set, fuse readback and preload are refused, while the signature stays readable and writable. Only the full erase clears the security bit. The erase walks the fuse array one word per cycle, clears the signature and the security bit, and keeps the port busy while it runs.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset the controller is ready, every response output and `pl_load` are low, `rsp_rdata` and `pl_value` are zero, and `secure_o` is low.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Every accepted command other than erase produces `rsp_done` high for exactly the cycle after acceptance. Operation codes: 0 write fuse, 1 verify fuse, 2 write signature, 3 read signature, 4 set security, 5 preload, 6 full erase, 7 reserved.
- R3: Write fuse stores `cmd_wdata` at fuse word `cmd_addr`. An unsecured verify returns that word on `rsp_rdata` with its done pulse. Every word is stored independently.
- R4: Signature bytes are addressed by `cmd_addr[2:0]`. A write stores `cmd_wdata[7:0]`. A read returns the byte in `rsp_rdata[7:0]` with the upper bits zero.
- R5: Set security raises `secure_o`. Repeating the command leaves it set, and no command other than full erase clears it.
- R6: A verify issued while secured completes with `rsp_denied` high for one cycle together with `rsp_done`, and `rsp_rdata` is zero.
- R7: An unsecured preload pulses `pl_load` for one cycle, together with `rsp_done`, with `pl_value` equal to `cmd_wdata[7:0]`. A secured preload is denied and `pl_load` stays low.
- R8: Signature reads succeed and are not denied while secured.
- R9: Security takes effect on the very next command: a verify accepted on the edge right after the set-security edge is denied.
- R10: A full erase holds `cmd_ready` low for `FUSE_WORDS` cycles and then pulses `rsp_done`. Afterwards all fuse words read zero, all signature bytes read zero, and `secure_o` is low.
- R11: `cmd_valid` asserted while `cmd_ready` is low is ignored: no done pulse and no state change.
- R12: Reserved code 7 completes with done and denied and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be accepted |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 4 | Fuse word address; bits 2:0 select a signature byte |
| cmd_wdata | input | 32 | Write data or preload value |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_denied | output | 1 | Command refused; valid with rsp_done |
| rsp_rdata | output | 32 | Read result; zero when not a successful read |
| secure_o | output | 1 | Current security bit |
| pl_load | output | 1 | One-cycle preload strobe to output registers |
| pl_value | output | 8 | Preload value |

## Verification
Fuse words are written with walking, alternating and all-ones patterns at the first, last and middle addresses. Reading them back shows whether words are kept apart or aliased. Verify and preload are each issued once before and once after security is set, back to back with the set command, so a one-cycle lag in the lock shows up as an accepted verify. Signature reads after the lock distinguish "lock everything" from the intended selective lock. An erase with stray requests driven during its busy window checks its cycle length, its complete clearing of all state, and that requests made while busy are ignored.

// File: rtl/cfg_pkg.sv
// Shared types for the configuration store controller.
// Assumes a 3-bit operation field on the command port.
package cfg_pkg;
    typedef enum logic [2:0] {
        OP_WR_FUSE = 3'd0,
        OP_VERIFY  = 3'd1,
        OP_WR_SIG  = 3'd2,
        OP_RD_SIG  = 3'd3,
        OP_SET_SEC = 3'd4,
        OP_PRELOAD = 3'd5,
        OP_ERASE   = 3'd6,
        OP_RSVD    = 3'd7
    } cfg_op_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ERASE = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/cfg_fuse_array.sv
// Fuse pattern storage: WORDS words of WIDTH bits.
// One write port, one clear port used by the erase sweep (clear wins on
// the same word), and a combinational read port.
// Assumes only one of write or clear targets a given word per cycle.
module cfg_fuse_array #(
    parameter int WORDS = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_en,
    input  logic [AW-1:0]    clr_addr,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Hold one fuse word; erase clear overrides a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (clr_en && clr_addr == AW'(g)) begin
                words[g] <= '0;
            end else if (wr_en && wr_addr == AW'(g)) begin
                words[g] <= wr_data;
            end
        end
    end

    // Read the addressed word.
    always_comb begin
        rd_data = words[rd_addr];
    end
endmodule

// File: rtl/cfg_sig_store.sv
// User signature storage, BYTES bytes, byte addressed.
// A clear input wipes all bytes at once and takes priority over a write.
module cfg_sig_store #(
    parameter int BYTES = 8,
    localparam int SAW  = $clog2(BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [SAW-1:0] addr,
    input  logic [7:0]     wr_byte,
    input  logic           clr_all,
    output logic [7:0]     rd_byte
);
    logic [7:0] bytes_q [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        // Hold one signature byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= '0;
            end else if (clr_all) begin
                bytes_q[g] <= '0;
            end else if (wr_en && addr == SAW'(g)) begin
                bytes_q[g] <= wr_byte;
            end
        end
    end

    // Read the addressed byte.
    always_comb begin
        rd_byte = bytes_q[addr];
    end
endmodule

// File: rtl/cfg_lock.sv
// Security bit. Set by the set command, cleared only by the erase clear
// strobe; clear wins when both arrive together.
module cfg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic secure
);
    // Sticky security bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secure <= 1'b0;
        end else if (clr_en) begin
            secure <= 1'b0;
        end else if (set_en) begin
            secure <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_seq.sv
// Command sequencer: accepts commands while idle, applies the security
// policy, drives the stores and registers the response one cycle later.
// The erase sweep clears one fuse word per cycle and finishes by clearing
// the signature and the security bit.
// Assumes the read data of the stores is combinational.
module cfg_seq
    import cfg_pkg::*;
#(
    parameter int FUSE_WORDS = 16,
    parameter int FUSE_W     = 32,
    parameter int SIG_BYTES  = 8,
    parameter int PL_W       = 8,
    localparam int AW        = $clog2(FUSE_WORDS),
    localparam int SAW       = $clog2(SIG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [FUSE_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic              rsp_denied,
    output logic [FUSE_W-1:0] rsp_rdata,
    output logic              pl_load,
    output logic [PL_W-1:0]   pl_value,
    input  logic              secure,
    input  logic [FUSE_W-1:0] fuse_rd_data,
    input  logic [7:0]        sig_rd_byte,
    output logic              fuse_wr_en,
    output logic              fuse_clr_en,
    output logic [AW-1:0]     fuse_clr_addr,
    output logic              sig_wr_en,
    output logic [SAW-1:0]    sig_addr,
    output logic              sig_clr,
    output logic              lock_set,
    output logic              lock_clr
);
    localparam logic [AW-1:0] LAST_WORD = AW'(FUSE_WORDS - 1);

    cfg_state_e  state_q;
    logic [AW-1:0] sweep_q;
    cfg_op_e     op;
    logic        accept;
    logic        erase_last;
    logic        locked_op;
    logic        deny;

    // Decode the command and the policy for this cycle.
    always_comb begin
        op            = cfg_op_e'(cmd_op);
        cmd_ready     = (state_q == ST_IDLE);
        accept        = cmd_valid && cmd_ready;
        erase_last    = (state_q == ST_ERASE) && (sweep_q == LAST_WORD);
        locked_op     = (op == OP_VERIFY) || (op == OP_PRELOAD);
        deny          = accept && ((locked_op && secure) || op == OP_RSVD);
        fuse_wr_en    = accept && op == OP_WR_FUSE;
        sig_wr_en     = accept && op == OP_WR_SIG;
        sig_addr      = cmd_addr[SAW-1:0];
        lock_set      = accept && op == OP_SET_SEC;
        fuse_clr_en   = (state_q == ST_ERASE);
        fuse_clr_addr = sweep_q;
        sig_clr       = erase_last;
        lock_clr      = erase_last;
    end

    // Control state: idle or erase sweep with its word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sweep_q <= '0;
        end else if (accept && op == OP_ERASE) begin
            state_q <= ST_ERASE;
            sweep_q <= '0;
        end else if (erase_last) begin
            state_q <= ST_IDLE;
            sweep_q <= '0;
        end else if (state_q == ST_ERASE) begin
            sweep_q <= sweep_q + 1'b1;
        end
    end

    // Registered response and preload strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done   <= 1'b0;
            rsp_denied <= 1'b0;
            rsp_rdata  <= '0;
            pl_load    <= 1'b0;
            pl_value   <= '0;
        end else begin
            rsp_done   <= (accept && op != OP_ERASE) || erase_last;
            rsp_denied <= deny;
            pl_load    <= accept && op == OP_PRELOAD && !secure;
            pl_value   <= (accept && op == OP_PRELOAD && !secure)
                          ? cmd_wdata[PL_W-1:0] : '0;
            if (accept && op == OP_VERIFY && !secure) begin
                rsp_rdata <= fuse_rd_data;
            end else if (accept && op == OP_RD_SIG) begin
                rsp_rdata <= {{(FUSE_W-8){1'b0}}, sig_rd_byte};
            end else begin
                rsp_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/cfg_store_ctrl.sv
// Top of the secured configuration store controller: fuse array,
// signature store, security bit and command sequencer.
// Assumes FUSE_W > 8 and SIG_BYTES a power of two no larger than FUSE_WORDS.
module cfg_store_ctrl #(
    parameter int FUSE_WORDS = 16,
    parameter int FUSE_W     = 32,
    parameter int SIG_BYTES  = 8,
    parameter int PL_W       = 8,
    localparam int AW        = $clog2(FUSE_WORDS),
    localparam int SAW       = $clog2(SIG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [FUSE_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic              rsp_denied,
    output logic [FUSE_W-1:0] rsp_rdata,
    output logic              secure_o,
    output logic              pl_load,
    output logic [PL_W-1:0]   pl_value
);
    logic              secure;
    logic [FUSE_W-1:0] fuse_rd_data;
    logic [7:0]        sig_rd_byte;
    logic              fuse_wr_en, fuse_clr_en, sig_wr_en, sig_clr;
    logic              lock_set, lock_clr;
    logic [AW-1:0]     fuse_clr_addr;
    logic [SAW-1:0]    sig_addr;

    cfg_seq #(
        .FUSE_WORDS(FUSE_WORDS), .FUSE_W(FUSE_W),
        .SIG_BYTES(SIG_BYTES), .PL_W(PL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_denied(rsp_denied), .rsp_rdata(rsp_rdata),
        .pl_load(pl_load), .pl_value(pl_value),
        .secure(secure), .fuse_rd_data(fuse_rd_data), .sig_rd_byte(sig_rd_byte),
        .fuse_wr_en(fuse_wr_en), .fuse_clr_en(fuse_clr_en),
        .fuse_clr_addr(fuse_clr_addr), .sig_wr_en(sig_wr_en),
        .sig_addr(sig_addr), .sig_clr(sig_clr),
        .lock_set(lock_set), .lock_clr(lock_clr)
    );

    cfg_fuse_array #(.WORDS(FUSE_WORDS), .WIDTH(FUSE_W)) u_fuse (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fuse_wr_en), .wr_addr(cmd_addr), .wr_data(cmd_wdata),
        .clr_en(fuse_clr_en), .clr_addr(fuse_clr_addr),
        .rd_addr(cmd_addr), .rd_data(fuse_rd_data)
    );

    cfg_sig_store #(.BYTES(SIG_BYTES)) u_sig (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sig_wr_en), .addr(sig_addr), .wr_byte(cmd_wdata[7:0]),
        .clr_all(sig_clr), .rd_byte(sig_rd_byte)
    );

    cfg_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .set_en(lock_set), .clr_en(lock_clr), .secure(secure)
    );

    // Expose the security bit.
    always_comb begin
        secure_o = secure;
    end
endmodule

// File: rtl/cfg_store_ctrl_chk.sv
// Protocol and policy checks for cfg_store_ctrl, attached by bind.
module cfg_store_ctrl_chk #(
    parameter int FUSE_W = 32,
    parameter int AW     = 4,
    parameter int PL_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [AW-1:0]     cmd_addr,
    input logic              rsp_done,
    input logic              rsp_denied,
    input logic [FUSE_W-1:0] rsp_rdata,
    input logic              secure_o,
    input logic              pl_load,
    input logic [PL_W-1:0]   pl_value
);
    // R2: non-erase command completes on the next cycle
    p_done_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 3'd6) |=> rsp_done);

    // R6: denial only with done, and with zero data
    p_denied_has_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_done && rsp_rdata == '0));

    // R7: no preload strobe when the lock was set at acceptance
    p_preload_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pl_load |-> (!$past(secure_o) && rsp_done && !rsp_denied));

    // R7: preload value is zero outside the strobe
    p_pl_value_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_load |-> pl_value == '0);

    // R5: security falls only at the end of an erase
    p_secure_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secure_o) |-> (rsp_done && $past(!cmd_ready)));

    // R10: busy only after accepting an erase
    p_busy_from_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_ready) |-> $past(cmd_valid && cmd_op == 3'd6));

    // R11: no done while busy unless it is the erase completion
    p_busy_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready)) |-> !rsp_done);

    logic unused_addr;
    always_comb unused_addr = ^cmd_addr;
endmodule

bind cfg_store_ctrl cfg_store_ctrl_chk #(
    .FUSE_W(FUSE_W), .AW(AW), .PL_W(PL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rsp_done(rsp_done),
    .rsp_denied(rsp_denied), .rsp_rdata(rsp_rdata), .secure_o(secure_o),
    .pl_load(pl_load), .pl_value(pl_value)
);

// File: tb/cfg_store_ctrl_tb_top.sv
// Directed bench for cfg_store_ctrl.
module cfg_store_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_done, rsp_denied, secure_o, pl_load;
    logic [31:0] rsp_rdata;
    logic [7:0]  pl_value;

    int checks = 0;
    int fails = 0;
    logic [31:0] exp_fuse [WORDS];
    logic [7:0]  exp_sig [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_store_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_denied(rsp_denied), .rsp_rdata(rsp_rdata),
        .secure_o(secure_o), .pl_load(pl_load), .pl_value(pl_value)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one command; return at the negedge after acceptance.
    task automatic cmd(logic [2:0] op, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ready", 32'(cmd_ready), 1);
        check("R1 done", 32'(rsp_done), 0);
        check("R1 denied", 32'(rsp_denied), 0);
        check("R1 rdata", rsp_rdata, 0);
        check("R1 secure", 32'(secure_o), 0);
        check("R1 pl_load", 32'(pl_load), 0);
        check("R1 pl_value", 32'(pl_value), 0);
    endtask

    task automatic t_fuse();
        logic [31:0] pats [4];
        logic [3:0]  adrs [4];
        pats[0] = 32'h0000_0001; pats[1] = 32'hAAAA_5555;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h1234_8765;
        adrs[0] = 4'd0; adrs[1] = 4'd15; adrs[2] = 4'd7; adrs[3] = 4'd8;
        for (int i = 0; i < 4; i++) begin
            cmd(3'd0, adrs[i], pats[i]);
            exp_fuse[adrs[i]] = pats[i];
            check("R2 write done", 32'(rsp_done), 1);
        end
        for (int i = 0; i < 4; i++) begin
            cmd(3'd1, adrs[i], 32'h0);
            check("R3 verify data", rsp_rdata, exp_fuse[adrs[i]]);
            check("R2 verify done", 32'(rsp_done), 1);
            check("R3 verify not denied", 32'(rsp_denied), 0);
        end
        @(negedge clk);
        check("R2 done single cycle", 32'(rsp_done), 0);
        cmd(3'd1, 4'd3, 32'h0);
        check("R3 unwritten word", rsp_rdata, 0);
    endtask

    task automatic t_sig();
        for (int i = 0; i < 8; i++) begin
            cmd(3'd2, 4'(i), {24'hFFFFFF, 8'(8'h11 * (i + 1))});
            exp_sig[i] = 8'(8'h11 * (i + 1));
        end
        for (int i = 7; i >= 0; i--) begin
            cmd(3'd3, 4'(i), 32'h0);
            check("R4 sig read", rsp_rdata, {24'h0, exp_sig[i]});
        end
    endtask

    task automatic t_preload_open();
        cmd(3'd5, 4'd0, 32'hDEAD_BE5A);
        check("R7 pl_load", 32'(pl_load), 1);
        check("R7 pl_value", 32'(pl_value), 32'h5A);
        check("R7 done", 32'(rsp_done), 1);
        @(negedge clk);
        check("R7 pl_load one cycle", 32'(pl_load), 0);
    endtask

    task automatic t_reserved();
        cmd(3'd7, 4'd0, 32'hFFFF_FFFF);
        check("R12 done", 32'(rsp_done), 1);
        check("R12 denied", 32'(rsp_denied), 1);
        cmd(3'd1, 4'd0, 32'h0);
        check("R12 fuse unchanged", rsp_rdata, exp_fuse[0]);
        check("R12 secure unchanged", 32'(secure_o), 0);
    endtask

    task automatic t_lock();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 4'd0; cmd_wdata = 0;
        @(negedge clk);
        check("R5 set done", 32'(rsp_done), 1);
        check("R5 secure set", 32'(secure_o), 1);
        cmd_op = 3'd1; cmd_addr = 4'd15;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 verify right after lock denied", 32'(rsp_denied), 1);
        check("R6 denied rdata zero", rsp_rdata, 0);
        check("R6 denied has done", 32'(rsp_done), 1);
        @(negedge clk);
        check("R6 denied one cycle", 32'(rsp_denied), 0);
        cmd(3'd5, 4'd0, 32'h0000_00C3);
        check("R7 secured preload denied", 32'(rsp_denied), 1);
        check("R7 secured no pl_load", 32'(pl_load), 0);
        cmd(3'd3, 4'd5, 32'h0);
        check("R8 sig readable secured", rsp_rdata, {24'h0, exp_sig[5]});
        check("R8 sig not denied", 32'(rsp_denied), 0);
        cmd(3'd4, 4'd0, 32'h0);
        check("R5 repeat set stays", 32'(secure_o), 1);
        cmd(3'd7, 4'd0, 32'h0);
        cmd(3'd0, 4'd2, 32'h0);
        check("R5 other commands keep lock", 32'(secure_o), 1);
    endtask

    task automatic t_erase();
        int k;
        cmd(3'd6, 4'd0, 32'h0);
        check("R10 busy", 32'(cmd_ready), 0);
        check("R10 no done at start", 32'(rsp_done), 0);
        k = 0;
        while (!rsp_done && k < 100) begin
            if (k == 3) begin
                cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 4'd1;
            end
            if (k == 6) cmd_valid = 1'b0;
            @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
        check("R10 erase length", 32'(k), 32'(WORDS));
        check("R11 busy request ignored", 32'(secure_o), 0);
        check("R10 ready after erase", 32'(cmd_ready), 1);
        for (int i = 0; i < WORDS; i += 5) begin
            cmd(3'd1, 4'(i), 32'h0);
            check("R10 fuse cleared", rsp_rdata, 0);
            check("R10 verify allowed", 32'(rsp_denied), 0);
        end
        cmd(3'd3, 4'd5, 32'h0);
        check("R10 sig cleared", rsp_rdata, 0);
        @(negedge clk);
        check("R11 no stray done", 32'(rsp_done), 0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) exp_fuse[i] = '0;
        for (int i = 0; i < 8; i++) exp_sig[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fuse();
        t_sig();
        t_preload_open();
        t_reserved();
        t_lock();
        t_erase();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule